// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Match

This peripheral keeps time as an unsigned 32-bit count of seconds. A prescaler divides the peripheral clock by `TICK_DIV` to make a one-cycle update strobe. On each strobe, the seconds counter either advances, takes a value that software loaded earlier, or returns to zero after an alarm match. The update strobe runs only while the counter-enable control bit is set.

Software uses a small synchronous register bus. Reads are registered, so read data is valid in the cycle after `re_i`. Through this bus, software can:
- program an alarm (match) value;
- queue a new counter value;
- set the control bits.

Any match raises a raw pending flag when the interrupt-enable bit is set. The mask bit gates that flag onto the interrupt pin and the masked status register. Reading the clear register drops the pending flag.

Top module: `sec_rtc`

## Requirements
- R1: Register word offsets: 0x00 counter (read-only), 0x04 match, 0x08 load, 0x0C control, 0x10 masked status, 0x14 raw status, 0x18 interrupt clear, 0x1C version (returns `VERSION_ID`). Byte address bits [1:0] are ignored. Any word index of 8 or more reads zero. Read data appears on `rdata_o` one cycle after `re_i` is asserted, and match, load and control read back what was written.
- R2: While control bit 2 (counter enable) is 1, the counter changes once every `TICK_DIV` clock cycles. While it is 0, the counter holds.
- R3: The prescaler restarts from zero whenever counter enable is 0. The first update comes on the `TICK_DIV`-th rising edge after the write that sets the enable bit.
- R4: A write to the load register does not change the counter at once. The counter takes the loaded value at the next update.
- R5: With control bit 3 (wrap enable) at 0, the counter advances from 0xFFFFFFFF to 0.
- R6: With wrap enable at 1, the counter goes to 0 at the update where its value equals the match value.
- R7: At an update where the counter equals the match value, raw status bit 0 (offset 0x14) sets if control bit 0 (interrupt enable) is 1. It stays clear if interrupt enable is 0.
- R8: `irq_o` and masked status bit 0 (0x10) equal raw status AND NOT control bit 1 (mask).
- R9: A read of offset 0x18 clears the raw status. A write to 0x18 leaves the raw status unchanged.
- R10: Writes to 0x00, 0x10, 0x14 and 0x1C have no effect.
- R11: After reset, the counter, match, load, control and both status bits are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Masked match interrupt |

## Verification
The bench builds the block with `TICK_DIV` set to 4, so one "second" lasts four clock cycles. This puts within reach of a short run:
- deferred loads;
- a wrap after a match;
- a full 0xFFFFFFFF-to-0 rollover (reached by loading a value near the top);
- a prescaler restart in the middle of a count.

`VERSION_ID` is set to a value other than its default, so the version read proves that the parameter reaches the register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    RI_COUNT = 3'd0,
    RI_MATCH = 3'd1,
    RI_LOAD  = 3'd2,
    RI_CTRL  = 3'd3,
    RI_MSTAT = 3'd4,
    RI_RSTAT = 3'd5,
    RI_CLEAR = 3'd6,
    RI_VER   = 3'd7
  } reg_idx_e;

  // bit0 irq_en, bit1 irq_mask, bit2 cnt_en, bit3 wrap_en
  typedef struct packed {
    logic wrap_en;
    logic cnt_en;
    logic irq_mask;
    logic irq_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (!en_i)         div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + PW'(1);
  end

  assign tick_o = en_i && (div_q == LAST);
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wrap_en_i,
  input  logic          load_wr_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] match_i,
  output logic [DW-1:0] count_o,
  output logic          hit_o
);
  logic [DW-1:0] cnt_q;
  logic          pend_q;
  logic          eq;

  assign eq = (cnt_q == match_i);

  // a write landing on an update edge waits for the following update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (load_wr_i) pend_q <= 1'b1;
    else if (tick_i)    pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) begin
      if (pend_q)               cnt_q <= load_val_i;
      else if (wrap_en_i && eq) cnt_q <= '0;
      else                      cnt_q <= cnt_q + DW'(1);
    end
  end

  assign count_o = cnt_q;
  assign hit_o   = tick_i && eq;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned AW         = 6,
  parameter int unsigned DW         = 32,
  parameter logic [31:0] VERSION_ID = 32'h0001_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] count_i,
  input  logic          hit_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] match_o,
  output logic [DW-1:0] load_val_o,
  output logic          load_wr_o,
  output logic          raw_o,
  output logic          irq_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] word_idx;
  logic          mapped;
  reg_idx_e      sel;
  ctrl_t         ctrl_q;
  logic [DW-1:0] match_q, load_q, rdata_q;
  logic          raw_q, masked;
  logic          unused_bits;

  assign word_idx    = addr_i[AW-1:2];
  assign mapped      = (word_idx >> 3) == '0;
  assign sel         = reg_idx_e'(word_idx[2:0]);
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:CTRL_W]};

  assign load_wr_o = we_i && mapped && (sel == RI_LOAD);
  assign masked    = raw_q && !ctrl_q.irq_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      match_q <= '0;
      load_q  <= '0;
    end else if (we_i && mapped) begin
      unique case (sel)
        RI_MATCH: match_q <= wdata_i;
        RI_LOAD:  load_q  <= wdata_i;
        RI_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  // a new match wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     raw_q <= 1'b0;
    else if (hit_i && ctrl_q.irq_en)                 raw_q <= 1'b1;
    else if (re_i && mapped && (sel == RI_CLEAR))    raw_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (re_i) begin
      if (!mapped) rdata_q <= '0;
      else begin
        unique case (sel)
          RI_COUNT: rdata_q <= count_i;
          RI_MATCH: rdata_q <= match_q;
          RI_LOAD:  rdata_q <= load_q;
          RI_CTRL:  rdata_q <= DW'(ctrl_q);
          RI_MSTAT: rdata_q <= DW'(masked);
          RI_RSTAT: rdata_q <= DW'(raw_q);
          RI_CLEAR: rdata_q <= '0;
          RI_VER:   rdata_q <= DW'(VERSION_ID);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign match_o    = match_q;
  assign load_val_o = load_q;
  assign raw_o      = raw_q;
  assign irq_o      = masked;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned AW         = 6,
  parameter int unsigned DW         = 32,
  parameter int unsigned TICK_DIV   = 32768,
  parameter logic [31:0] VERSION_ID = 32'h0001_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          tick, hit, load_wr, raw;
  logic [DW-1:0] count, match, load_val;

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.cnt_en),
    .tick_o (tick)
  );

  rtc_sec_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .wrap_en_i  (ctrl.wrap_en),
    .load_wr_i  (load_wr),
    .load_val_i (load_val),
    .match_i    (match),
    .count_o    (count),
    .hit_o      (hit)
  );

  rtc_regfile #(.AW(AW), .DW(DW), .VERSION_ID(VERSION_ID)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .re_i       (re_i),
    .rdata_o    (rdata_o),
    .count_i    (count),
    .hit_i      (hit),
    .ctrl_o     (ctrl),
    .match_o    (match),
    .load_val_o (load_val),
    .load_wr_o  (load_wr),
    .raw_o      (raw),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          re_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] count,
  input logic          tick,
  input logic          hit,
  input logic          raw,
  input logic          irq_en,
  input logic          irq_mask,
  input logic          cnt_en,
  input logic          irq_o
);
  logic clr_rd;
  assign clr_rd = re_i && (addr_i[AW-1:2] == (AW-2)'(6));

  a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en |=> $stable(count));

  a_r2_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count) |-> $past(tick));

  a_r7_raw_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw) |-> $past(hit && irq_en));

  a_r9_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rd && !(hit && irq_en)) |=> !raw);

  a_r8_mask_blocks_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask |-> !irq_o);
endmodule

bind sec_rtc sec_rtc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .re_i     (re_i),
  .addr_i   (addr_i),
  .count    (count),
  .tick     (tick),
  .hit      (hit),
  .raw      (raw),
  .irq_en   (ctrl.irq_en),
  .irq_mask (ctrl.irq_mask),
  .cnt_en   (ctrl.cnt_en),
  .irq_o    (irq_o)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
  localparam int unsigned AW  = 6;
  localparam int unsigned DW  = 32;
  localparam logic [31:0] VER = 32'hA5C3_0102;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  // counter update edges land at P0+4k, P0 = edge of vector 5
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   8'h0C, 32'h0,  32'h0,  4'd11}, // R11 control
    '{OP_RD,   8'h14, 32'h0,  32'h0,  4'd11}, // R11 raw status
    '{OP_RD,   8'h1C, 32'h0,  VER,    4'd1 }, // R1 version
    '{OP_RD,   8'h00, 32'h0,  32'h0,  4'd11}, // R11 counter
    '{OP_WR,   8'h04, 32'h3,  32'h0,  4'd1 },
    '{OP_WR,   8'h0C, 32'h4,  32'h0,  4'd2 }, // enable at P0
    '{OP_RD,   8'h00, 32'h0,  32'h0,  4'd3 }, // R3 no early update
    '{OP_IDLE, 8'h00, 32'd3,  32'h0,  4'd0 },
    '{OP_RD,   8'h00, 32'h0,  32'h1,  4'd2 }, // R2 first second
    '{OP_WR,   8'h08, 32'h10, 32'h0,  4'd4 },
    '{OP_RD,   8'h00, 32'h0,  32'h1,  4'd4 }, // R4 load deferred
    '{OP_RD,   8'h00, 32'h0,  32'h1,  4'd4 },
    '{OP_RD,   8'h00, 32'h0,  32'h10, 4'd4 }, // R4 loaded at update
    '{OP_RD,   8'h08, 32'h0,  32'h10, 4'd1 },
    '{OP_RD,   8'h04, 32'h0,  32'h3,  4'd1 },
    '{OP_WR,   8'h00, 32'hDEAD, 32'h0, 4'd10},
    '{OP_RD,   8'h00, 32'h0,  32'h11, 4'd10}, // R10 counter write ignored
    '{OP_RD,   8'h24, 32'h0,  32'h0,  4'd1 }, // R1 unmapped
    '{OP_WR,   8'h1C, 32'h0,  32'h0,  4'd10},
    '{OP_RD,   8'h1C, 32'h0,  VER,    4'd10},
    '{OP_RD,   8'h0C, 32'h0,  32'h4,  4'd1 },
    '{OP_WR,   8'h14, 32'h1,  32'h0,  4'd10},
    '{OP_RD,   8'h14, 32'h0,  32'h0,  4'd10}  // R10 status write ignored
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  sec_rtc #(.AW(AW), .DW(DW), .TICK_DIV(4), .VERSION_ID(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a[AW-1:0]; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a[AW-1:0]; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R11 irq after reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   wr(VECS[i].addr, VECS[i].data);
        OP_RD: begin
          rd(VECS[i].addr, v);
          chk($sformatf("R%0d vec %0d", VECS[i].req, i), v, VECS[i].exp);
        end
        default: idle(int'(VECS[i].data));
      endcase
    end

    // R7/R8/R9: match with interrupt enabled; update edges at P0+4k
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h5);
    wr(8'h04, 32'h6);
    wr(8'h0C, 32'h5);           // P0
    idle(11);
    chk("R7 no irq before match", 32'(irq), 32'h0);
    idle(1);
    chk("R7 irq at match update", 32'(irq), 32'h1);
    rd(8'h14, v); chk("R7 raw status", v, 32'h1);
    rd(8'h10, v); chk("R8 masked status", v, 32'h1);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R9 write to clear ignored", v, 32'h1);
    wr(8'h0C, 32'h7);
    chk("R8 mask hides irq", 32'(irq), 32'h0);
    rd(8'h10, v); chk("R8 masked status under mask", v, 32'h0);
    rd(8'h14, v); chk("R8 raw kept under mask", v, 32'h1);
    rd(8'h18, v);
    rd(8'h14, v); chk("R9 read clears raw", v, 32'h0);
    wr(8'h0C, 32'h5);
    chk("R9 irq stays low after clear", 32'(irq), 32'h0);

    // R6: wrap to 0 at match, interrupt disabled
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h2);
    wr(8'h0C, 32'hC);           // P0
    idle(15);
    rd(8'h00, v); chk("R6 reaches match", v, 32'h2);
    rd(8'h00, v); chk("R6 wraps after match", v, 32'h0);
    rd(8'h14, v); chk("R7 no raw with irq_en clear", v, 32'h0);

    // R5: full-range rollover
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h04, 32'h5);
    wr(8'h0C, 32'h4);           // P0
    idle(7);
    rd(8'h00, v); chk("R5 top value", v, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R5 rollover to zero", v, 32'h0);

    // R2: disabled counter holds
    wr(8'h0C, 32'h0);
    idle(10);
    rd(8'h00, v); chk("R2 hold while disabled", v, 32'h0);

    // R3: prescaler restart mid-count
    wr(8'h0C, 32'h4);
    idle(2);
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h4);           // Q1
    idle(3);
    rd(8'h00, v); chk("R3 restart delays update", v, 32'h0);
    rd(8'h00, v); chk("R3 update after full period", v, 32'h1);

    finish_run();
  end
endmodule